// File: doc/BRIEF.md
# Writeback Slot Allocator

This block keeps a short schedule of future writeback cycles. Each cycle of the schedule has a fixed number of write slots, and the schedule reaches a fixed number of cycles ahead. Finished instructions arrive on several request ports in the same clock, and each request carries an instruction tag. For each request the block finds the earliest free slot, counted as cycle offset times width plus slot index, and records the tag there. When every slot of the nearest cycle is taken, the result moves into a later cycle. If no free slot remains anywhere, the request is refused and an overflow flag is raised.

The nearest cycle of the schedule, called the head, is shown to a commit-side consumer. On every clock the schedule moves forward by one cycle. The head leaves, and a fresh empty cycle enters at the far end. Placement offset 0 means the cycle that becomes the head after the next clock edge. The block keeps a count of valid entries for every scheduled cycle and drives those counts out.

Top module: `wb_slot_alloc`

## Requirements
- R1: A granted request is placed at the lowest linear position (offset × WB_W + slot) that is free after this clock's advance. The search starts at offset 0, slot 0 in every clock, whatever was granted in earlier clocks. The placement is shown combinationally on `pl_cyc` and `pl_slot`.
- R2: Requests in one clock are served in port order, starting from port 0. Each port sees the slots already claimed by lower-numbered ports in that clock. Two granted ports p < q therefore always satisfy pos(p) < pos(q).
- R3: When every slot of a cycle offset is taken, the search goes on at slot 0 of the next offset. A result therefore spills into a later cycle.
- R4: A valid request that finds no free position in the WB_W × WB_DEPTH capacity raises its bit in `pl_ovf` in the same clock. Its tag is not stored and no count changes for it. After such a clock, every slot of the schedule is occupied.
- R5: `occ_cnt` field d (bits d×CNT_W upward) holds the number of valid entries in cycle offset d. It rises by one for each insertion into that cycle.
- R6: Every clock the schedule moves one cycle toward the head. The entries and the count of offset d+1 become those of offset d, and the farthest offset enters empty with a count of zero before any insertion.
- R7: `rd_valid` and `rd_tag` show the head cycle in slot order. Lane k is valid only when head slots 0 through k are all occupied. At most ISSUE_W lanes are shown. Lane k's tag is at `rd_tag` bits k×TAG_W upward.
- R8: After reset the schedule is empty: all counts are zero and no `rd_valid` bit is set.
- R9: A port with `req_valid` low takes no slot and never raises its overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | One request per port |
| req_tag | input | N_PORTS×TAG_W | Tag of port p at bits p×TAG_W |
| pl_cyc | output | N_PORTS×CYC_W | Granted cycle offset per port |
| pl_slot | output | N_PORTS×SLOT_W | Granted slot index per port |
| pl_ovf | output | N_PORTS | Request refused, schedule full |
| rd_valid | output | ISSUE_W | Head lanes shown to the consumer |
| rd_tag | output | ISSUE_W×TAG_W | Head tags, in slot order |
| occ_cnt | output | WB_DEPTH×CNT_W | Entry count per cycle offset |

## Verification
An occupancy bit that is lost or stuck inside the schedule shows up in the same clock as a wrong `pl_cyc` or `pl_slot` for the next request that searches past it. It also shows up in `occ_cnt` right after the next edge. A count or entry that is not shifted correctly reaches the head within WB_DEPTH clocks, where it appears as a wrong `rd_valid` prefix or a wrong tag. Port order and spill errors appear as placements that differ from the earliest-free rule computed in the bench.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // Linear position arithmetic for a schedule of width-wide cycles.
  function automatic int lin_pos(input int cyc, input int slot, input int width);
    return cyc * width + slot;
  endfunction

  function automatic int cyc_of(input int pos, input int width);
    return pos / width;
  endfunction

  function automatic int slot_of(input int pos, input int width);
    return pos % width;
  endfunction
endpackage

// File: rtl/wbs_search.sv
module wbs_search #(
  parameter int N_PORTS = 4,
  parameter int CAP     = 9,
  parameter int POS_W   = 4
) (
  input  logic [CAP-1:0]                  occ_view,
  input  logic [N_PORTS-1:0]              req_valid,
  output logic [N_PORTS-1:0][CAP-1:0]     grant_hot,
  output logic [N_PORTS-1:0][POS_W-1:0]   grant_pos,
  output logic [N_PORTS-1:0]              ovf
);
  // Chained first-free search: each port sees the claims of lower ports.
  always_comb begin
    logic [CAP-1:0] taken;
    logic           found;
    taken     = occ_view;
    grant_hot = '0;
    grant_pos = '0;
    ovf       = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      found = 1'b0;
      if (req_valid[p]) begin
        for (int i = 0; i < CAP; i++) begin
          if (!found && !taken[i]) begin
            found           = 1'b1;
            grant_hot[p][i] = 1'b1;
            grant_pos[p]    = POS_W'(i);
          end
        end
        if (found) taken = taken | grant_hot[p];
        else       ovf[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbs_store.sv
module wbs_store #(
  parameter int TAG_W   = 6,
  parameter int WB_W    = 3,
  parameter int DEPTH   = 3,
  parameter int N_PORTS = 4,
  parameter int CNT_W   = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_PORTS-1:0][WB_W*DEPTH-1:0]     grant_hot,
  input  logic [N_PORTS*TAG_W-1:0]               req_tag,
  output logic [WB_W*DEPTH-1:0]                  occ_view,
  output logic [DEPTH-1:0][WB_W-1:0]             st_valid,
  output logic [DEPTH-1:0][WB_W-1:0][TAG_W-1:0]  st_tag,
  output logic [DEPTH-1:0][CNT_W-1:0]            st_cnt
);
  logic [DEPTH-1:0][WB_W-1:0]            sh_valid, nx_valid;
  logic [DEPTH-1:0][WB_W-1:0][TAG_W-1:0] sh_tag, nx_tag;
  logic [DEPTH-1:0][CNT_W-1:0]           sh_cnt, nx_cnt;
  logic                                  tail_hit;

  // Shifted view: what the schedule looks like after this clock's advance.
  for (genvar d = 0; d < DEPTH; d++) begin : g_shift
    if (d < DEPTH - 1) begin : g_mid
      assign sh_valid[d] = st_valid[d+1];
      assign sh_tag[d]   = st_tag[d+1];
      assign sh_cnt[d]   = st_cnt[d+1];
    end else begin : g_tail
      assign sh_valid[d] = '0;
      assign sh_tag[d]   = '0;
      assign sh_cnt[d]   = '0;
    end
    for (genvar s = 0; s < WB_W; s++) begin : g_lin
      assign occ_view[d*WB_W+s] = sh_valid[d][s];
    end
  end

  always_comb begin
    nx_valid = sh_valid;
    nx_tag   = sh_tag;
    nx_cnt   = sh_cnt;
    tail_hit = 1'b0;
    for (int d = 0; d < DEPTH; d++) begin
      for (int s = 0; s < WB_W; s++) begin
        for (int p = 0; p < N_PORTS; p++) begin
          if (grant_hot[p][d*WB_W+s]) begin
            nx_valid[d][s] = 1'b1;
            nx_tag[d][s]   = req_tag[p*TAG_W +: TAG_W];
            nx_cnt[d]      = nx_cnt[d] + CNT_W'(1);
            if (d == DEPTH - 1) tail_hit = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= '0;
      st_tag   <= '0;
      st_cnt   <= '0;
    end else begin
      st_valid <= nx_valid;
      st_tag   <= nx_tag;
      st_cnt   <= nx_cnt;
    end
  end

  // R5: the count register of each cycle agrees with its valid bits.
  for (genvar d = 0; d < DEPTH; d++) begin : g_chk
    a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      st_cnt[d] == CNT_W'($countones(st_valid[d])));
  end

  // R6: with no insertion into the tail, the tail enters with a zero count.
  a_r6_tail_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_hit |=> st_cnt[DEPTH-1] == '0);
endmodule

// File: rtl/wbs_head.sv
module wbs_head #(
  parameter int TAG_W   = 6,
  parameter int WB_W    = 3,
  parameter int ISSUE_W = 2
) (
  input  logic [WB_W-1:0]             row_valid,
  input  logic [WB_W-1:0][TAG_W-1:0]  row_tag,
  output logic [ISSUE_W-1:0]          rd_valid,
  output logic [ISSUE_W*TAG_W-1:0]    rd_tag
);
  // Slot-order read that stops at the first hole or at ISSUE_W lanes.
  always_comb begin
    logic alive;
    alive = 1'b1;
    for (int k = 0; k < ISSUE_W; k++) begin
      alive                      = alive & row_valid[k];
      rd_valid[k]                = alive;
      rd_tag[k*TAG_W +: TAG_W]   = alive ? row_tag[k] : '0;
    end
  end
endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc #(
  parameter int TAG_W    = 6,
  parameter int WB_W     = 3,
  parameter int WB_DEPTH = 3,
  parameter int N_PORTS  = 4,
  parameter int ISSUE_W  = 2,
  localparam int CAP     = WB_W * WB_DEPTH,
  localparam int POS_W   = (CAP > 1) ? $clog2(CAP) : 1,
  localparam int CYC_W   = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1,
  localparam int SLOT_W  = (WB_W > 1) ? $clog2(WB_W) : 1,
  localparam int CNT_W   = $clog2(WB_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          req_valid,
  input  logic [N_PORTS*TAG_W-1:0]    req_tag,
  output logic [N_PORTS*CYC_W-1:0]    pl_cyc,
  output logic [N_PORTS*SLOT_W-1:0]   pl_slot,
  output logic [N_PORTS-1:0]          pl_ovf,
  output logic [ISSUE_W-1:0]          rd_valid,
  output logic [ISSUE_W*TAG_W-1:0]    rd_tag,
  output logic [WB_DEPTH*CNT_W-1:0]   occ_cnt
);
  import wbs_pkg::*;

  logic [CAP-1:0]                            occ_view;
  logic [N_PORTS-1:0][CAP-1:0]               grant_hot;
  logic [N_PORTS-1:0][POS_W-1:0]             grant_pos;
  logic [WB_DEPTH-1:0][WB_W-1:0]             st_valid;
  logic [WB_DEPTH-1:0][WB_W-1:0][TAG_W-1:0]  st_tag;
  logic [WB_DEPTH-1:0][CNT_W-1:0]            st_cnt;
  logic [N_PORTS-1:0]                        granted;

  wbs_search #(.N_PORTS(N_PORTS), .CAP(CAP), .POS_W(POS_W)) u_search (
    .occ_view (occ_view),
    .req_valid(req_valid),
    .grant_hot(grant_hot),
    .grant_pos(grant_pos),
    .ovf      (pl_ovf)
  );

  wbs_store #(.TAG_W(TAG_W), .WB_W(WB_W), .DEPTH(WB_DEPTH),
              .N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_hot(grant_hot),
    .req_tag  (req_tag),
    .occ_view (occ_view),
    .st_valid (st_valid),
    .st_tag   (st_tag),
    .st_cnt   (st_cnt)
  );

  wbs_head #(.TAG_W(TAG_W), .WB_W(WB_W), .ISSUE_W(ISSUE_W)) u_head (
    .row_valid(st_valid[0]),
    .row_tag  (st_tag[0]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_place
    assign granted[p] = req_valid[p] & ~pl_ovf[p];
    assign pl_cyc[p*CYC_W +: CYC_W]    = CYC_W'(cyc_of(int'(grant_pos[p]), WB_W));
    assign pl_slot[p*SLOT_W +: SLOT_W] = SLOT_W'(slot_of(int'(grant_pos[p]), WB_W));
  end

  for (genvar d = 0; d < WB_DEPTH; d++) begin : g_cnt
    assign occ_cnt[d*CNT_W +: CNT_W] = st_cnt[d];
  end

  function automatic int total_count(input logic [WB_DEPTH-1:0][CNT_W-1:0] c);
    int t;
    t = 0;
    for (int d = 0; d < WB_DEPTH; d++) t += int'(c[d]);
    return t;
  endfunction

  // R2: lower ports always land earlier in linear order.
  for (genvar p = 0; p < N_PORTS; p++) begin : g_ord
    for (genvar q = p + 1; q < N_PORTS; q++) begin : g_ordq
      a_r2_port_order: assert property (@(posedge clk) disable iff (!rst_n)
        (granted[p] && granted[q]) |->
          lin_pos(int'(pl_cyc[p*CYC_W +: CYC_W]), int'(pl_slot[p*SLOT_W +: SLOT_W]), WB_W) <
          lin_pos(int'(pl_cyc[q*CYC_W +: CYC_W]), int'(pl_slot[q*SLOT_W +: SLOT_W]), WB_W));
    end
    // R9: an idle port never reports overflow.
    a_r9_idle_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |-> !pl_ovf[p]);
  end

  // R4: a refused request means the schedule is completely full afterwards.
  a_r4_full_after_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (|pl_ovf) |=> total_count(st_cnt) == CAP);

  // R7: head lanes form a prefix starting at lane 0.
  a_r7_head_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_valid & (rd_valid + ISSUE_W'(1))) == '0));
endmodule

// File: tb/wb_slot_alloc_test.sv
module wb_slot_alloc_test;
  localparam int TW = 6, W = 3, D = 3, NP = 4, IW = 2;
  localparam int CAP = W * D, CYW = 2, SLW = 2, CNW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]     req_valid = '0;
  logic [NP*TW-1:0]  req_tag = '0;
  logic [NP*CYW-1:0] pl_cyc;
  logic [NP*SLW-1:0] pl_slot;
  logic [NP-1:0]     pl_ovf;
  logic [IW-1:0]     rd_valid;
  logic [IW*TW-1:0]  rd_tag;
  logic [D*CNW-1:0]  occ_cnt;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int tag_ctr = 0;

  bit          mv [D][W];
  logic [TW-1:0] mt [D][W];

  always #4 clk = ~clk;

  wb_slot_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .pl_cyc(pl_cyc), .pl_slot(pl_slot), .pl_ovf(pl_ovf),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .occ_cnt(occ_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Head lanes and counts against the model (called between edges).
  task automatic check_state();
    bit alive;
    alive = 1;
    for (int k = 0; k < IW; k++) begin
      alive = alive & mv[0][k];
      check(rd_valid[k] == alive, "R7 head valid", rd_valid[k], alive);
      if (alive)
        check(rd_tag[k*TW +: TW] == mt[0][k], "R7 head tag",
              rd_tag[k*TW +: TW], mt[0][k]);
    end
    for (int d = 0; d < D; d++) begin
      int e;
      e = 0;
      for (int s = 0; s < W; s++) e += mv[d][s];
      check(occ_cnt[d*CNW +: CNW] == e, (d == D-1) ? "R6 tail count" : "R5 count",
            occ_cnt[d*CNW +: CNW], e);
    end
  endtask

  // One clock: drive mask, check placements, advance the model.
  task automatic step(input logic [NP-1:0] mask);
    @(negedge clk);
    check_state();
    req_valid = mask;
    for (int p = 0; p < NP; p++) begin
      req_tag[p*TW +: TW] = TW'(tag_ctr);
      tag_ctr++;
    end
    #1;
    // model advance (shift) then placement scan
    for (int d = 0; d < D; d++)
      for (int s = 0; s < W; s++) begin
        mv[d][s] = (d < D-1) ? mv[d+1][s] : 1'b0;
        mt[d][s] = (d < D-1) ? mt[d+1][s] : '0;
      end
    for (int p = 0; p < NP; p++) begin
      int pos;
      pos = -1;
      if (mask[p]) begin
        for (int i = 0; i < CAP; i++)
          if (pos < 0 && !mv[i / W][i % W]) pos = i;
        if (pos < 0) begin
          check(pl_ovf[p] == 1'b1, "R4 overflow raised", pl_ovf[p], 1);
        end else begin
          check(pl_ovf[p] == 1'b0, "R4 no overflow", pl_ovf[p], 0);
          check(pl_cyc[p*CYW +: CYW] == pos / W, (pos >= W) ? "R3 spill cycle" : "R1/R2 cycle",
                pl_cyc[p*CYW +: CYW], pos / W);
          check(pl_slot[p*SLW +: SLW] == pos % W, "R1/R2 slot",
                pl_slot[p*SLW +: SLW], pos % W);
          mv[pos / W][pos % W] = 1'b1;
          mt[pos / W][pos % W] = req_tag[p*TW +: TW];
        end
      end else begin
        check(pl_ovf[p] == 1'b0, "R9 idle port", pl_ovf[p], 0);
      end
    end
  endtask

  initial begin
    for (int d = 0; d < D; d++)
      for (int s = 0; s < W; s++) begin mv[d][s] = 0; mt[d][s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(occ_cnt == '0, "R8 reset counts", occ_cnt, 0);
    check(rd_valid == '0, "R8 reset head", rd_valid, 0);
    rst_n = 1'b1;
    // each port alone
    for (int p = 0; p < NP; p++) begin
      step(NP'(1) << p);
      step('0);
    end
    // every mask
    for (int m = 0; m < 16; m++) begin
      step(NP'(m));
      step(NP'(m));
    end
    // saturate to force spill and overflow
    repeat (8) step('1);
    // drain
    repeat (4) step('0);
    // mixed sweep
    for (int i = 0; i < 300; i++) step(NP'((i * 7) ^ (i >> 2)));
    repeat (4) step('0);
    @(negedge clk);
    check_state();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule